// File: doc/BRIEF.md
# Dual Camera Luminance Capture and Averaging

This block takes two 8-bit parallel camera streams, each with its own pixel clock, frame sync (`*_vsync`) and line-valid (`*_href`) signal. The streams carry YCbCr 4:2:2 bytes in the order chroma, luma, chroma, luma. For each camera the block keeps only the luminance byte of every pixel and cuts it to its upper `LUMA_W` bits. It then writes the result, in row-major order, to the write port of a frame memory for that camera. The memories themselves sit outside the block.

A third write port feeds a monitor frame. Each of its pixels is the truncated mean of the left and right luminance at the same address. The two cameras run at the same rate but need not be aligned. A small matching queue per camera absorbs a lag of up to `SKEW_PIX` pixels between them, so an averaged pixel is written only once both of its inputs exist. A one-cycle `frame_done` pulse reports that both cameras have written the last pixel of the frame.

All logic runs on the system clock `clk`. Camera signals are sampled on it and each pixel clock is edge-detected, so `clk` must run at least twice as fast as a camera pixel clock.

Top module: `dual_luma_capture`

## Requirements
- R1: The block writes only the second byte of each byte pair while href is high (the luma byte, pair phase restarting at each line and frame start). The stored value is bits [7:8-LUMA_W] of that byte. Chroma bytes and bytes taken while href is low are never written.
- R2: Write addresses are row-major, `row*COLS + col`. The column restarts at 0 on each line, and the row increments on each falling edge of href, both sampled at pixel-clock rising edges.
- R3: A rising edge of vsync returns the row, column and pair phase to zero, so the next frame starts at address 0 even if the previous frame was cut short.
- R4: Luma bytes beyond column COLS-1 of a line and lines beyond row ROWS-1 produce no write. Every address written is below COLS*ROWS.
- R5: Each camera is captured independently onto its own write port. A fixed lag of one camera behind the other does not change the address or data written for either.
- R6: For every address written by both cameras, the averaged port writes that address exactly once with data `(L+R)>>1`, where L and R are the two stored values. Averaged writes occur in address order.
- R7: With the cameras offset by up to SKEW_PIX pixels in either direction, no pixel is lost from the averaged stream: its write count equals the per-camera write count.
- R8: `frame_done` is high for exactly one `clk` cycle. That cycle comes one cycle after the later of the two cameras writes address COLS*ROWS-1, and there is one pulse per completed frame.
- R9: While reset is held and right after its release, with no camera activity, no write enable and no `frame_done` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_pclk | input | 1 | Left camera pixel clock |
| l_vsync | input | 1 | Left camera frame sync |
| l_href | input | 1 | Left camera line valid |
| l_data | input | 8 | Left camera byte bus |
| r_pclk | input | 1 | Right camera pixel clock |
| r_vsync | input | 1 | Right camera frame sync |
| r_href | input | 1 | Right camera line valid |
| r_data | input | 8 | Right camera byte bus |
| l_wr_en | output | 1 | Left frame memory write enable |
| l_wr_addr | output | AW | Left frame memory address |
| l_wr_data | output | LUMA_W | Left frame memory data |
| r_wr_en | output | 1 | Right frame memory write enable |
| r_wr_addr | output | AW | Right frame memory address |
| r_wr_data | output | LUMA_W | Right frame memory data |
| a_wr_en | output | 1 | Averaged frame memory write enable |
| a_wr_addr | output | AW | Averaged frame memory address |
| a_wr_data | output | LUMA_W | Averaged frame memory data |
| frame_done | output | 1 | One-cycle pulse when both frames are complete |

## Verification
Two events can land in the same `clk` cycle: both cameras can write a pixel at once, and both can write the final pixel of a frame at once. When that happens, the matching queues push on both sides while the pair from the previous pixel is popped, and the two completion flags have to merge into a single `frame_done` pulse. The bench provokes this with frames driven at zero lag, and provokes the opposite case with lags of up to the full skew limit on either camera. It judges every write port against a reference image built from the bytes it sent. It also checks that `frame_done` appears exactly once per complete frame and only after both last-pixel writes have been observed.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
   typedef enum logic {
      PH_CHROMA = 1'b0,
      PH_LUMA   = 1'b1
   } byte_phase_e;
endpackage

// File: rtl/dlc_capture.sv
module dlc_capture
   import dlc_pkg::*;
#(
   parameter int COLS   = 320,
   parameter int ROWS   = 240,
   parameter int LUMA_W = 4,
   parameter int AW     = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pclk,
   input  logic              vsync,
   input  logic              href,
   input  logic [7:0]        data,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [LUMA_W-1:0] wr_data,
   output logic              last
);
   localparam int CW = $clog2(COLS + 1);
   localparam int RW = $clog2(ROWS + 1);
   localparam logic [CW-1:0] COL_LIM   = CW'(COLS);
   localparam logic [RW-1:0] ROW_LIM   = RW'(ROWS);
   localparam logic [AW-1:0] ROW_STEP  = AW'(COLS);
   localparam logic [AW-1:0] LAST_ADDR = AW'(COLS * ROWS - 1);

   logic          pclk_q, pclk_qq, vs_q, hr_q;
   logic [7:0]    d_q;
   logic          vs_prev, hr_prev;
   byte_phase_e   phase;
   logic [CW-1:0] col;
   logic [RW-1:0] row;
   logic [AW-1:0] base;
   logic [AW-1:0] pix_addr;
   logic          rise;

   assign rise     = pclk_q & ~pclk_qq;
   assign pix_addr = base + AW'(col);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pclk_q  <= 1'b0;
         pclk_qq <= 1'b0;
         vs_q    <= 1'b0;
         hr_q    <= 1'b0;
         d_q     <= '0;
      end else begin
         pclk_q  <= pclk;
         pclk_qq <= pclk_q;
         vs_q    <= vsync;
         hr_q    <= href;
         d_q     <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_prev <= 1'b0;
         hr_prev <= 1'b0;
         phase   <= PH_CHROMA;
         col     <= '0;
         row     <= '0;
         base    <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         last    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         last  <= 1'b0;
         if (rise) begin
            vs_prev <= vs_q;
            hr_prev <= hr_q;
            if (vs_q && !vs_prev) begin
               phase <= PH_CHROMA;
               col   <= '0;
               row   <= '0;
               base  <= '0;
            end else if (hr_q) begin
               if (phase == PH_LUMA) begin
                  phase <= PH_CHROMA;
                  if (col < COL_LIM && row < ROW_LIM) begin
                     wr_en   <= 1'b1;
                     wr_addr <= pix_addr;
                     wr_data <= d_q[7 -: LUMA_W];
                     last    <= (pix_addr == LAST_ADDR);
                  end
                  if (col < COL_LIM) col <= col + CW'(1);
               end else begin
                  phase <= PH_LUMA;
               end
            end else if (hr_prev) begin
               phase <= PH_CHROMA;
               col   <= '0;
               if (row < ROW_LIM) begin
                  row  <= row + RW'(1);
                  base <= base + ROW_STEP;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dlc_skew_fifo.sv
module dlc_skew_fifo #(
   parameter int DEPTH = 5,
   parameter int W     = 21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH == 1) begin : g_single
         logic         valid;
         logic [W-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid <= 1'b0;
               hold  <= '0;
            end else if (push && (!valid || pop)) begin
               valid <= 1'b1;
               hold  <= din;
            end else if (pop && valid) begin
               valid <= 1'b0;
            end
         end
         assign dout  = hold;
         assign empty = ~valid;
         assign full  = valid;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int NW = $clog2(DEPTH + 1);
         localparam logic [PW-1:0] PTR_TOP = PW'(DEPTH - 1);
         localparam logic [NW-1:0] CNT_TOP = NW'(DEPTH);

         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] wp, rp;
         logic [NW-1:0] cnt;
         logic          do_push, do_pop;

         assign empty   = (cnt == '0);
         assign full    = (cnt == CNT_TOP);
         assign do_pop  = pop & ~empty;
         assign do_push = push & (~full | do_pop);
         assign dout    = mem[rp];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (do_push) wp <= (wp == PTR_TOP) ? '0 : wp + PW'(1);
               if (do_pop)  rp <= (rp == PTR_TOP) ? '0 : rp + PW'(1);
               if (do_push && !do_pop)      cnt <= cnt + NW'(1);
               else if (do_pop && !do_push) cnt <= cnt - NW'(1);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wp] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/dual_luma_capture.sv
module dual_luma_capture #(
   parameter int COLS     = 320,
   parameter int ROWS     = 240,
   parameter int LUMA_W   = 4,
   parameter int SKEW_PIX = 4,
   parameter int NPIX     = COLS * ROWS,
   parameter int AW       = $clog2(NPIX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_pclk,
   input  logic              l_vsync,
   input  logic              l_href,
   input  logic [7:0]        l_data,
   input  logic              r_pclk,
   input  logic              r_vsync,
   input  logic              r_href,
   input  logic [7:0]        r_data,
   output logic              l_wr_en,
   output logic [AW-1:0]     l_wr_addr,
   output logic [LUMA_W-1:0] l_wr_data,
   output logic              r_wr_en,
   output logic [AW-1:0]     r_wr_addr,
   output logic [LUMA_W-1:0] r_wr_data,
   output logic              a_wr_en,
   output logic [AW-1:0]     a_wr_addr,
   output logic [LUMA_W-1:0] a_wr_data,
   output logic              frame_done
);
   localparam int QDEPTH = SKEW_PIX + 1;
   localparam int QW     = AW + LUMA_W;

   generate
      if (LUMA_W < 1 || LUMA_W > 8) begin : g_bad_luma
         $error("LUMA_W must lie in 1..8");
      end
      if (COLS < 2 || ROWS < 1) begin : g_bad_size
         $error("frame must be at least 2x1 pixels");
      end
      if (SKEW_PIX < 0) begin : g_bad_skew
         $error("SKEW_PIX must not be negative");
      end
      if (NPIX != COLS * ROWS) begin : g_bad_npix
         $error("NPIX must equal COLS*ROWS");
      end
   endgenerate

   logic              in_pclk  [2];
   logic              in_vsync [2];
   logic              in_href  [2];
   logic [7:0]        in_data  [2];
   logic              cap_we   [2];
   logic [AW-1:0]     cap_addr [2];
   logic [LUMA_W-1:0] cap_data [2];
   logic              cap_last [2];
   logic [QW-1:0]     q_dout   [2];
   logic              q_empty  [2];
   logic              q_full   [2];
   logic              q_pop;
   logic [1:0]        seen_last;
   logic [1:0]        fin;

   assign in_pclk[0]  = l_pclk;
   assign in_vsync[0] = l_vsync;
   assign in_href[0]  = l_href;
   assign in_data[0]  = l_data;
   assign in_pclk[1]  = r_pclk;
   assign in_vsync[1] = r_vsync;
   assign in_href[1]  = r_href;
   assign in_data[1]  = r_data;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cam
         dlc_capture #(
            .COLS(COLS), .ROWS(ROWS), .LUMA_W(LUMA_W), .AW(AW)
         ) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .pclk   (in_pclk[i]),
            .vsync  (in_vsync[i]),
            .href   (in_href[i]),
            .data   (in_data[i]),
            .wr_en  (cap_we[i]),
            .wr_addr(cap_addr[i]),
            .wr_data(cap_data[i]),
            .last   (cap_last[i])
         );

         dlc_skew_fifo #(.DEPTH(QDEPTH), .W(QW)) u_q (
            .clk  (clk),
            .rst_n(rst_n),
            .push (cap_we[i]),
            .din  ({cap_addr[i], cap_data[i]}),
            .pop  (q_pop),
            .dout (q_dout[i]),
            .empty(q_empty[i]),
            .full (q_full[i])
         );

         assign fin[i] = seen_last[i] | cap_last[i];
      end
   endgenerate

   assign l_wr_en   = cap_we[0];
   assign l_wr_addr = cap_addr[0];
   assign l_wr_data = cap_data[0];
   assign r_wr_en   = cap_we[1];
   assign r_wr_addr = cap_addr[1];
   assign r_wr_data = cap_data[1];

   assign q_pop = ~q_empty[0] & ~q_empty[1];

   logic [LUMA_W:0] pair_sum;
   assign pair_sum = {1'b0, q_dout[0][LUMA_W-1:0]} + {1'b0, q_dout[1][LUMA_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_wr_en   <= 1'b0;
         a_wr_addr <= '0;
         a_wr_data <= '0;
      end else begin
         a_wr_en <= q_pop;
         if (q_pop) begin
            a_wr_addr <= q_dout[0][LUMA_W +: AW];
            a_wr_data <= pair_sum[LUMA_W:1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_last  <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= &fin;
         seen_last  <= (&fin) ? 2'b00 : fin;
      end
   end
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
   parameter int AW   = 17,
   parameter int NPIX = 76800
) (
   input logic          clk,
   input logic          rst_n,
   input logic          l_wr_en,
   input logic [AW-1:0] l_wr_addr,
   input logic          r_wr_en,
   input logic [AW-1:0] r_wr_addr,
   input logic          a_wr_en,
   input logic [AW-1:0] a_wr_addr,
   input logic          frame_done,
   input logic          pop,
   input logic          l_empty,
   input logic          r_empty,
   input logic          l_full,
   input logic          r_full,
   input logic [AW-1:0] l_head,
   input logic [AW-1:0] r_head
);
   localparam logic [AW-1:0] LAST = AW'(NPIX - 1);

   // R9: outputs idle on the first cycle after reset release
   a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!l_wr_en && !r_wr_en && !a_wr_en && !frame_done));

   // R4: addresses stay inside the frame
   a_r4_left_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      l_wr_en |-> (l_wr_addr <= LAST));
   a_r4_right_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      r_wr_en |-> (r_wr_addr <= LAST));

   // R7: matching queues never drop a pixel within the skew limit
   a_r7_left_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_wr_en && l_full && !pop));
   a_r7_right_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_wr_en && r_full && !pop));

   // R6: paired entries refer to the same pixel and produce a write next cycle
   a_r6_heads_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_empty && !r_empty) |-> (l_head == r_head));
   a_r6_avg_follows_pair: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (a_wr_en && a_wr_addr == $past(l_head)));

   // R8: completion is a single-cycle pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
endmodule

bind dual_luma_capture dlc_checker #(.AW(AW), .NPIX(NPIX)) u_dlc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .l_wr_en   (l_wr_en),
   .l_wr_addr (l_wr_addr),
   .r_wr_en   (r_wr_en),
   .r_wr_addr (r_wr_addr),
   .a_wr_en   (a_wr_en),
   .a_wr_addr (a_wr_addr),
   .frame_done(frame_done),
   .pop       (q_pop),
   .l_empty   (q_empty[0]),
   .r_empty   (q_empty[1]),
   .l_full    (q_full[0]),
   .r_full    (q_full[1]),
   .l_head    (q_dout[0][LUMA_W +: AW]),
   .r_head    (q_dout[1][LUMA_W +: AW])
);

// File: tb/dual_luma_capture_bench.sv
module dual_luma_capture_bench;
   localparam int COLS = 8;
   localparam int ROWS = 4;
   localparam int LW   = 4;
   localparam int SKEW = 4;
   localparam int NPIX = COLS * ROWS;
   localparam int AW   = $clog2(NPIX);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_pclk = 0, l_vsync = 0, l_href = 0;
   logic r_pclk = 0, r_vsync = 0, r_href = 0;
   logic [7:0] l_data = '0, r_data = '0;
   logic l_wr_en, r_wr_en, a_wr_en, frame_done;
   logic [AW-1:0] l_wr_addr, r_wr_addr, a_wr_addr;
   logic [LW-1:0] l_wr_data, r_wr_data, a_wr_data;

   always #5 clk = ~clk;

   dual_luma_capture #(.COLS(COLS), .ROWS(ROWS), .LUMA_W(LW), .SKEW_PIX(SKEW)) u_dual_luma_capture (
      .clk(clk), .rst_n(rst_n),
      .l_pclk(l_pclk), .l_vsync(l_vsync), .l_href(l_href), .l_data(l_data),
      .r_pclk(r_pclk), .r_vsync(r_vsync), .r_href(r_href), .r_data(r_data),
      .l_wr_en(l_wr_en), .l_wr_addr(l_wr_addr), .l_wr_data(l_wr_data),
      .r_wr_en(r_wr_en), .r_wr_addr(r_wr_addr), .r_wr_data(r_wr_data),
      .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
      .frame_done(frame_done)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   logic [7:0] ly [ROWS+1][COLS+2];
   logic [7:0] ry [ROWS+1][COLS+2];
   int exp_l [NPIX];
   int exp_r [NPIX];
   int lnext = 0, rnext = 0, anext = 0, done_cnt = 0;

   function automatic int luma(input logic [7:0] b);
      return int'(b[7 -: LW]);
   endfunction

   function automatic int mean2(input int a, input int b);
      return (a + b) >> 1;
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // write monitors, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (l_wr_en) begin
            check(int'(l_wr_addr) == lnext, "R2", "left address order (R3 restart)", int'(l_wr_addr), lnext);
            check(int'(l_wr_data) == exp_l[l_wr_addr], "R1", "left luma value", int'(l_wr_data), exp_l[l_wr_addr]);
            lnext++;
         end
         if (r_wr_en) begin
            check(int'(r_wr_addr) == rnext, "R5", "right address order", int'(r_wr_addr), rnext);
            check(int'(r_wr_data) == exp_r[r_wr_addr], "R5", "right luma value", int'(r_wr_data), exp_r[r_wr_addr]);
            rnext++;
         end
         if (a_wr_en) begin
            check(int'(a_wr_addr) == anext, "R6", "average address order", int'(a_wr_addr), anext);
            check(int'(a_wr_data) == mean2(exp_l[a_wr_addr], exp_r[a_wr_addr]), "R6", "average value",
                  int'(a_wr_data), mean2(exp_l[a_wr_addr], exp_r[a_wr_addr]));
            anext++;
         end
         if (frame_done) begin
            check(lnext == NPIX && rnext == NPIX, "R8", "done before both last pixels (left count)", lnext, NPIX);
            done_cnt++;
         end
      end
   end

   task automatic drive(input bit rt, input logic vs, input logic hr, input logic [7:0] d);
      if (rt) begin r_vsync = vs; r_href = hr; r_data = d; end
      else    begin l_vsync = vs; l_href = hr; l_data = d; end
      #20;
      if (rt) r_pclk = 1'b1; else l_pclk = 1'b1;
      #20;
      if (rt) r_pclk = 1'b0; else l_pclk = 1'b0;
   endtask

   task automatic send_cam(input bit rt, input int delay_px, input int nrows, input int ncols);
      #(delay_px * 80);
      for (int k = 0; k < 2; k++) drive(rt, 1'b1, 1'b0, 8'h00);
      for (int k = 0; k < 2; k++) drive(rt, 1'b0, 1'b0, 8'h00);
      for (int r = 0; r < nrows; r++) begin
         for (int b = 0; b < 2 * ncols; b++) begin
            if (b % 2 == 1) drive(rt, 1'b0, 1'b1, rt ? ry[r][b/2] : ly[r][b/2]);
            else            drive(rt, 1'b0, 1'b1, 8'($urandom));
         end
         for (int k = 0; k < 3; k++) drive(rt, 1'b0, 1'b0, 8'($urandom));
      end
      for (int k = 0; k < 2; k++) drive(rt, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic run_frame(input int nrows, input int ncols, input int lskew, input int rskew, input string tag);
      int rows_w, cols_w, nwr, done0;
      for (int r = 0; r <= ROWS; r++)
         for (int c = 0; c < COLS + 2; c++) begin
            ly[r][c] = 8'($urandom);
            ry[r][c] = 8'($urandom);
         end
      for (int a = 0; a < NPIX; a++) begin exp_l[a] = -1; exp_r[a] = -1; end
      rows_w = (nrows < ROWS) ? nrows : ROWS;
      cols_w = (ncols < COLS) ? ncols : COLS;
      for (int r = 0; r < rows_w; r++)
         for (int c = 0; c < cols_w; c++) begin
            exp_l[r * COLS + c] = luma(ly[r][c]);
            exp_r[r * COLS + c] = luma(ry[r][c]);
         end
      nwr   = rows_w * cols_w;
      lnext = 0; rnext = 0; anext = 0;
      done0 = done_cnt;
      @(posedge clk); #2;
      fork
         send_cam(1'b0, lskew, nrows, ncols);
         send_cam(1'b1, rskew, nrows, ncols);
      join
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(lnext == nwr, "R4", {tag, " left write count"}, lnext, nwr);
      check(rnext == nwr, "R5", {tag, " right write count"}, rnext, nwr);
      check(anext == nwr, "R7", {tag, " average write count"}, anext, nwr);
      check(done_cnt - done0 == ((nwr == NPIX) ? 1 : 0), "R8", {tag, " done pulses"},
            done_cnt - done0, (nwr == NPIX) ? 1 : 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!l_wr_en && !r_wr_en && !a_wr_en && !frame_done, "R9", "outputs in reset", 0, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!l_wr_en && !r_wr_en && !a_wr_en && !frame_done, "R9", "outputs after reset", 0, 0);

      run_frame(ROWS, COLS, 0, 0, "aligned");
      run_frame(ROWS, COLS, 0, SKEW, "right lags max");
      run_frame(ROWS, COLS, SKEW, 0, "left lags max");
      run_frame(2, COLS, 0, 1, "cut short R3");
      run_frame(ROWS, COLS, 1, 0, "after cut R3");
      run_frame(ROWS + 1, COLS + 2, 0, 2, "oversize R4");
      for (int n = 0; n < 4; n++) begin
         int sk = int'($urandom_range(0, SKEW));
         if ($urandom_range(0, 1) == 1) run_frame(ROWS, COLS, sk, 0, "random left lag");
         else                           run_frame(ROWS, COLS, 0, sk, "random right lag");
      end
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule